// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block settles compare-and-branch instructions for a 32-bit RISC core whose instructions are fixed 32-bit immediate-format words. It holds the program counter in a register. Each cycle it decodes the presented instruction word and compares the two register operand values that were read for the instruction's source fields. From these it produces the next program counter, a taken flag and a misaligned-destination exception.

Two branch kinds are recognised: branch-if-equal and branch-if-signed-greater-or-equal. The branch displacement is a signed byte count relative to the address that follows the branch, so a taken branch goes to PC + 4 + sign-extended immediate. A non-branch opcode simply falls through to PC + 4. A taken branch whose destination is not word-aligned does not update the program counter. Instead, the exception flag is raised for one cycle.

Top module: `cbr_unit`

## Requirements
- R1: After reset the registered program counter `pc` equals parameter `RESET_ADDR` (default 0x0000_0100), and `exc` is 0.
- R2: The instruction word is laid out as source index A in bits 31:27, source index B in bits 26:22, a signed byte displacement in bits 21:6 and the opcode in bits 5:0. `src_a_idx` and `src_b_idx` present bits 31:27 and 26:22.
- R3: With opcode `OP_EQ` (default 0x26), the branch is taken when `opa == opb` over all 32 bits. A taken branch gives `next_pc = pc + 4 + sign-extended displacement`.
- R4: With opcode `OP_GE` (default 0x0E), the branch is taken when `opa >= opb` as two's-complement values, with the same target arithmetic as R3.
- R5: When a recognised branch's condition fails, `next_pc = pc + 4` and `taken = 0`.
- R6: Any other opcode gives `next_pc = pc + 4`, `taken = 0`, and never raises `exc`.
- R7: `taken` is 0 while `in_valid` is 0. `pc` loads `next_pc` on a clock edge only when `in_valid` is 1 and no exception is being raised; otherwise it holds its value.
- R8: A taken branch whose target has bits 1:0 not both zero raises `exc` in the following cycle for that one cycle only, and leaves `pc` unchanged.
- R9: All target arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Value of the register selected by field A |
| opb | input | 32 | Value of the register selected by field B |
| src_a_idx | output | 5 | Register index from field A |
| src_b_idx | output | 5 | Register index from field B |
| pc | output | 32 | Registered program counter |
| next_pc | output | 32 | Resolved next program counter for this cycle |
| taken | output | 1 | Branch taken this cycle |
| exc | output | 1 | Misaligned destination exception, one cycle after the branch |

## Verification
Several rules are checked on every clock by assertions: the program counter holds when the input is not valid, and it also holds when a misaligned target is raised. An exception never appears without a misaligned taken branch in the cycle before it. A non-branch opcode never reports taken, and a taken branch always lands on the value reported the cycle before. The signed-versus-unsigned compare boundaries, the exact encoding of the displacement, and address wrap-around are shown only by the bench's scenarios. Those scenarios are compared with a behavioural model on every cycle.

// File: rtl/cbr_unit.sv
module cbr_unit #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IDXW       = 5,
  parameter int unsigned IMMW       = 16,
  parameter int unsigned OPW        = 6,
  parameter logic [31:0] RESET_ADDR = 32'h0000_0100,
  parameter logic [5:0]  OP_EQ      = 6'h26,
  parameter logic [5:0]  OP_GE      = 6'h0e
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [IDXW-1:0] src_a_idx,
  output logic [IDXW-1:0] src_b_idx,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic            exc
);
  localparam int unsigned OP_LO  = 0;
  localparam int unsigned IMM_LO = OP_LO + OPW;
  localparam int unsigned B_LO   = IMM_LO + IMMW;
  localparam int unsigned A_LO   = B_LO + IDXW;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [OPW-1:0]  opcode;
  logic [IMMW-1:0] imm;
  logic [XLEN-1:0] disp, seq_pc, tgt_pc;
  logic            is_eq, is_ge, cond, bad_tgt;

  assign src_a_idx = instr[A_LO +: IDXW];
  assign src_b_idx = instr[B_LO +: IDXW];
  assign opcode    = instr[OP_LO +: OPW];
  assign imm       = instr[IMM_LO +: IMMW];
  assign disp      = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};

  assign is_eq = (opcode == OP_EQ[OPW-1:0]);
  assign is_ge = (opcode == OP_GE[OPW-1:0]);

  always_comb begin
    cond = 1'b0;
    if (is_eq)      cond = (opa == opb);
    else if (is_ge) cond = ($signed(opa) >= $signed(opb));
  end

  assign seq_pc  = pc + STEP;
  assign tgt_pc  = seq_pc + disp;
  assign taken   = in_valid & cond;
  assign next_pc = taken ? tgt_pc : seq_pc;
  assign bad_tgt = taken & (tgt_pc[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= RESET_ADDR;
      exc <= 1'b0;
    end else begin
      exc <= bad_tgt;
      if (in_valid && !bad_tgt) pc <= next_pc;
    end
  end
endmodule

module cbr_unit_chk #(
  parameter logic [5:0] OP_EQ = 6'h26,
  parameter logic [5:0] OP_GE = 6'h0e
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic        taken,
  input logic        exc
);
  logic nonbr, misal;
  assign nonbr = (instr[5:0] != OP_EQ) && (instr[5:0] != OP_GE);
  assign misal = taken && (next_pc[1:0] != 2'b00);

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pc));
  a_r7_no_taken_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !taken);
  a_r8_hold_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    misal |=> (exc && $stable(pc)));
  a_r8_exc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> $past(misal));
  a_r6_nonbranch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nonbr) |-> (!taken && next_pc == pc + 32'd4));
  a_r3_land: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !misal) |=> (pc == $past(next_pc)));
endmodule

bind cbr_unit cbr_unit_chk #(.OP_EQ(OP_EQ), .OP_GE(OP_GE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
  .pc(pc), .next_pc(next_pc), .taken(taken), .exc(exc));

// File: tb/sim_cbr_unit.sv
module sim_cbr_unit;
  localparam logic [5:0] OPEQ = 6'h26;
  localparam logic [5:0] OPGE = 6'h0e;
  localparam logic [31:0] RST = 32'h0000_0100;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [31:0] instr = '0, opa = '0, opb = '0;
  logic [4:0]  src_a_idx, src_b_idx;
  logic [31:0] pc, next_pc;
  logic        taken, exc;
  int errs = 0, checks = 0;
  logic [31:0] mpc;
  logic        mexc;

  always #2 clk = ~clk;

  cbr_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .opa(opa), .opb(opb), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .pc(pc), .next_pc(next_pc), .taken(taken), .exc(exc));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int a, int b, int imm, logic [5:0] op);
    logic [4:0] fa = 5'(a);
    logic [4:0] fb = 5'(b);
    logic [15:0] fi = 16'(imm);
    return {fa, fb, fi, op};
  endfunction

  task automatic step(string req, logic v, logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    logic cond, etk;
    logic [31:0] tgt, enx;
    longint sa, sb;
    @(negedge clk);
    in_valid = v; instr = ins; opa = a; opb = b;
    #1;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    cond = 1'b0;
    if (ins[5:0] == OPEQ) cond = (a == b);
    else if (ins[5:0] == OPGE) cond = (sa >= sb);
    etk = v && cond;
    tgt = 32'((longint'(mpc) + 4 + longint'($signed(ins[21:6]))) & 64'hFFFF_FFFF);
    enx = etk ? tgt : mpc + 32'd4;
    chk({req, " R1/R8 pc"}, pc, mpc);
    chk({req, " R8 exc"}, {31'b0, exc}, {31'b0, mexc});
    chk({req, " taken R7"}, {31'b0, taken}, {31'b0, etk});
    chk({req, " next_pc"}, next_pc, enx);
    chk("R2 idx", {22'b0, src_a_idx, src_b_idx}, {22'b0, ins[31:27], ins[26:22]});
    @(posedge clk);
    mexc = etk && (tgt[1:0] != 2'b00);
    if (v && !mexc) mpc = enx;
  endtask

  initial begin
    #200000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    mpc = RST; mexc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", pc, RST);
    chk("R1 reset exc", {31'b0, exc}, 32'b0);
    rst_n = 1'b1;
    step("R3 eq fwd",       1, mk(3, 4, 16, OPEQ), 32'd7, 32'd7);
    step("R5 eq miss",      1, mk(3, 4, 16, OPEQ), 32'd7, 32'd8);
    step("R3 eq back",      1, mk(1, 2, -12, OPEQ), 32'hdead_beef, 32'hdead_beef);
    step("R4 ge neg<pos",   1, mk(5, 6, 32, OPGE), 32'hffff_fff0, 32'd5);
    step("R4 ge pos>neg",   1, mk(5, 6, 32, OPGE), 32'd5, 32'hffff_fff0);
    step("R4 ge equal",     1, mk(5, 6, -8, OPGE), 32'h8000_0000, 32'h8000_0000);
    step("R4 ge min<max",   1, mk(5, 6, 4, OPGE), 32'h8000_0000, 32'h7fff_ffff);
    step("R6 other op",     1, mk(9, 9, 64, 6'h04), 32'd1, 32'd1);
    step("R7 idle",         0, mk(0, 0, 64, OPEQ), 32'd0, 32'd0);
    step("R7 idle2",        0, mk(0, 0, 64, OPEQ), 32'd0, 32'd0);
    step("R8 misaligned",   1, mk(2, 2, 2, OPEQ), 32'd3, 32'd3);
    step("R8 after",        1, mk(2, 2, 8, OPEQ), 32'd3, 32'd4);
    step("R8 misal ge",     1, mk(2, 2, 1, OPGE), 32'd3, 32'd3);
    step("R8 misal again",  1, mk(2, 2, 3, OPEQ), 32'd3, 32'd3);
    step("R8 clear",        1, mk(0, 0, 0, 6'h00), 32'd0, 32'd0);
    step("R9 wrap down",    1, mk(0, 0, -32768, OPEQ), 32'd0, 32'd0);
    step("R9 wrap up",      1, mk(0, 0, 32764, OPEQ), 32'd0, 32'd0);
    for (int i = 0; i < 200; i++) begin
      logic [31:0] x = $urandom;
      logic [31:0] y = (i % 3 == 0) ? x : $urandom;
      logic [5:0]  op = (i % 4 == 0) ? OPEQ : (i % 4 == 1) ? OPGE : (i % 4 == 2) ? 6'(i) : OPEQ;
      int im = int'($signed(16'($urandom))) & ((i % 7 == 0) ? -1 : -4);
      step("R9 mix", (i % 5) != 0, mk(i, i + 3, im, op), x, y);
    end
    @(negedge clk);
    chk("R1 end pc", pc, mpc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule